// File: doc/BRIEF.md
# E1 Transmit Timeslot-Zero Formatter

This block assembles the outgoing E1 bit stream from a serial payload input. An internal position counter tracks the 256-bit frame and the even/odd frame alternation. Timeslot 0 is overwritten or kept according to two source controls. One control governs the international bit. The other governs the seven alignment, alarm and spare bits that follow it. All other timeslots pass through unchanged. Each input bit is taken on a single-cycle strobe that marks the 2.048 MHz bit rate.

The formatted stream appears as a registered NRZ output. The same stream also drives a dual-rail line coder, which produces plain AMI or, when enabled, HDB3 with four-zero substitution. The coder is a pair of two-state machines. Its polarity machine has the states LAST_NEG and LAST_POS. A mark or a B pulse takes the transition FLIP to the other state. A violation takes HOLD and stays in the same state. The parity machine has the states CNT_EVEN and CNT_ODD. It takes TOGGLE on each incoming mark, and RESET_EVEN when a substitution is started. A settings word selects the modes. An illegal combination of controls, or a nonzero reserved bit, raises a registered error flag.

Top module: `e1_ts0_formatter`

## Requirements
- R1: In timeslot 0 (frame bit positions 0..7, position 0 sent first), positions 1..7 come from the serial input when ctrl[7]=1. When ctrl[7]=0 they come from the frame's register byte, bits 6 down to 0 in that order. Even frames use fas_byte and odd frames use nfas_byte.
- R2: Position 0 of timeslot 0 (the international bit) is taken from the serial input when ctrl[4]=0. When ctrl[4]=1 and ctrl[7]=0 it is bit 7 of the frame's register byte.
- R3: When ctrl[7]=1 and ctrl[4]=1 together, cfg_err is 1 one clock later, and the international bit comes from the serial input.
- R4: Any nonzero value in ctrl bits 6, 5, 3, 2 or 0 sets cfg_err one clock later. cfg_err is 0 one clock after a legal word.
- R5: Bits at frame positions 8..255 pass unchanged. nrz_out shows the formatted bit of the sample taken at a strobe, one clock after that strobe.
- R6: A frame is 256 strobes. The first strobe after reset is position 0 of an even frame, and frames alternate even and odd.
- R7: line_pos and line_neg are never both 1. They change only after a strobe. After the strobe for input n they encode the formatted bit of input n-4. Ordinary pulses alternate polarity, and the first pulse after reset is positive.
- R8: With ctrl[1]=1 (HDB3), each run of four zeros is sent as 000V or B00V. V has the polarity of the preceding pulse. B is chosen so that the number of pulses between successive violations is odd. Decoding the rails recovers the formatted stream exactly.
- R9: With ctrl[1]=1, no more than three consecutive strobes ever show both rails at 0, once the pipeline holds data.
- R10: With ctrl[1]=0 the rails carry AMI. A zero gives no pulse, every one gives a pulse of alternating polarity, and no violation ever appears.
- R11: During reset, nrz_out, line_pos, line_neg and cfg_err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle strobe per line bit |
| ser_in | input | 1 | Serial payload bit, sampled on bit_en |
| ctrl | input | 8 | Mode word: bit 7 pass-through, bit 4 international bit from register, bit 1 HDB3, others reserved 0 |
| fas_byte | input | 8 | Timeslot-0 byte for even frames |
| nfas_byte | input | 8 | Timeslot-0 byte for odd frames |
| nrz_out | output | 1 | Formatted NRZ stream |
| line_pos | output | 1 | Positive rail pulse |
| line_neg | output | 1 | Negative rail pulse |
| cfg_err | output | 1 | Illegal control combination or reserved bit set |

## Verification
Assertions check four things on every cycle: the rails never overlap and change only on a strobe, payload bits pass through, the frame parity turns over at the wrap, and the error flag answers both error conditions. A counter-based property also bounds the zero runs on the HDB3 line. Some behaviour only the bench's scenarios can show. One is that the decoded rails reproduce the formatted stream. Another is that B00V is chosen so that each gap between violations holds an odd pulse count. The last is that the timeslot-0 fields follow the selected sources across even and odd frames. The bench covers these with random payloads, an all-zero line and the illegal control words.

// File: rtl/e1tx_pkg.sv
package e1tx_pkg;
    // symbol carried through the line coder pipeline
    typedef enum logic [1:0] {SYM_ZERO, SYM_MARK, SYM_BPUL, SYM_VPUL} sym_t;
    // polarity of the most recent pulse on the line
    typedef enum logic {LAST_NEG, LAST_POS} pol_t;
    // parity of pulses sent since the last violation
    typedef enum logic {CNT_EVEN, CNT_ODD} par_t;

    localparam int CTL_PASS  = 7;
    localparam int CTL_SIREG = 4;
    localparam int CTL_HDB3  = 1;
    localparam logic [7:0] CTL_RSVD_MASK = 8'b0110_1101;
endpackage

// File: rtl/e1_frame_pos.sv
module e1_frame_pos #(
    parameter int SLOTS     = 32,
    parameter int SLOT_BITS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bit_en,
    output logic                         ts0,
    output logic [$clog2(SLOT_BITS)-1:0] ts0_bit,
    output logic                         odd_frame
);
    localparam int FRAME_BITS = SLOTS * SLOT_BITS;
    localparam int CW         = $clog2(FRAME_BITS);
    localparam int SB_W       = $clog2(SLOT_BITS);

    logic [CW-1:0] bit_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            odd_frame <= 1'b0;
        end else if (bit_en) begin
            if (bit_cnt == CW'(FRAME_BITS - 1)) begin
                bit_cnt   <= '0;
                odd_frame <= ~odd_frame;
            end else begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        ts0     = (bit_cnt < CW'(SLOT_BITS));
        ts0_bit = bit_cnt[SB_W-1:0];
    end

    // R6: parity of the frame turns over exactly at the end of a frame
    p_frame_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && bit_cnt == CW'(FRAME_BITS - 1)) |=> (odd_frame != $past(odd_frame)));
    p_frame_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en) |=> $stable(odd_frame));
endmodule

// File: rtl/e1_ts0_insert.sv
module e1_ts0_insert #(
    parameter int SLOT_BITS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bit_en,
    input  logic                         ser_in,
    input  logic                         ts0,
    input  logic [$clog2(SLOT_BITS)-1:0] ts0_bit,
    input  logic                         odd_frame,
    input  logic                         pass_thru,
    input  logic                         si_from_reg,
    input  logic [SLOT_BITS-1:0]         fas_byte,
    input  logic [SLOT_BITS-1:0]         nfas_byte,
    output logic                         fmt_bit,
    output logic                         nrz_out
);
    localparam int SB_W = $clog2(SLOT_BITS);

    logic [SLOT_BITS-1:0] cur_byte;
    logic                 reg_bit;

    always_comb begin
        cur_byte = odd_frame ? nfas_byte : fas_byte;
        reg_bit  = cur_byte[SB_W'(SLOT_BITS - 1) - ts0_bit];
        fmt_bit  = ser_in;
        if (ts0) begin
            if (ts0_bit == '0)
                fmt_bit = (si_from_reg && !pass_thru) ? reg_bit : ser_in;
            else
                fmt_bit = pass_thru ? ser_in : reg_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      nrz_out <= 1'b0;
        else if (bit_en) nrz_out <= fmt_bit;
    end

    // R5: payload outside timeslot 0 is carried through untouched
    p_payload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !ts0) |=> (nrz_out == $past(ser_in)));
    // R1: with pass-through set the whole field follows the serial input
    p_pass_field_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && pass_thru) |=> (nrz_out == $past(ser_in)));
endmodule

// File: rtl/e1_line_coder.sv
module e1_line_coder
    import e1tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic hdb3_en,
    input  logic din,
    output logic line_pos,
    output logic line_neg
);
    localparam int DEPTH = 4;

    sym_t pipe_q [DEPTH];
    sym_t pipe_d [DEPTH];
    pol_t pol_q, pol_d;
    par_t par_q, par_d;
    logic pos_d, neg_d;
    logic subst;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) pipe_q[i] <= SYM_ZERO;
            pol_q    <= LAST_NEG;
            par_q    <= CNT_EVEN;
            line_pos <= 1'b0;
            line_neg <= 1'b0;
        end else if (bit_en) begin
            for (int i = 0; i < DEPTH; i++) pipe_q[i] <= pipe_d[i];
            pol_q    <= pol_d;
            par_q    <= par_d;
            line_pos <= pos_d;
            line_neg <= neg_d;
        end
    end

    // next state and outputs
    always_comb begin
        subst = hdb3_en && !din && (pipe_q[0] == SYM_ZERO)
                && (pipe_q[1] == SYM_ZERO) && (pipe_q[2] == SYM_ZERO);
        pipe_d[0] = subst ? SYM_VPUL : (din ? SYM_MARK : SYM_ZERO);
        pipe_d[1] = pipe_q[0];
        pipe_d[2] = pipe_q[1];
        pipe_d[3] = (subst && par_q == CNT_EVEN) ? SYM_BPUL : pipe_q[2];

        unique case (par_q)
            CNT_EVEN: par_d = (din && !subst) ? CNT_ODD : CNT_EVEN;
            CNT_ODD:  par_d = subst ? CNT_EVEN : (din ? CNT_EVEN : CNT_ODD);
        endcase

        pol_d = pol_q;
        pos_d = 1'b0;
        neg_d = 1'b0;
        unique case (pipe_q[DEPTH-1])
            SYM_ZERO: ;
            SYM_MARK, SYM_BPUL: begin
                pol_d = (pol_q == LAST_POS) ? LAST_NEG : LAST_POS;
                pos_d = (pol_q == LAST_NEG);
                neg_d = (pol_q == LAST_POS);
            end
            SYM_VPUL: begin
                pos_d = (pol_q == LAST_POS);
                neg_d = (pol_q == LAST_NEG);
            end
        endcase
    end

    // checker state: strobes since HDB3 on, zero run seen on the rails
    logic [2:0] age_q;
    logic [2:0] zrun_q;
    always_ff @(posedge clk) begin
        if (!rst_n || !hdb3_en) begin
            age_q  <= '0;
            zrun_q <= '0;
        end else if (bit_en) begin
            if (age_q != 3'd7) age_q <= age_q + 1'b1;
            if (age_q < 3'd5)                 zrun_q <= '0;
            else if (line_pos || line_neg)    zrun_q <= '0;
            else if (zrun_q != 3'd7)          zrun_q <= zrun_q + 1'b1;
        end
    end

    p_rail_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_pos && line_neg));
    p_rail_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en) |=> ($stable(line_pos) && $stable(line_neg)));
    p_zero_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        zrun_q <= 3'd3);
endmodule

// File: rtl/e1_ts0_formatter.sv
module e1_ts0_formatter
    import e1tx_pkg::*;
#(
    parameter int SLOTS     = 32,
    parameter int SLOT_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_en,
    input  logic                 ser_in,
    input  logic [7:0]           ctrl,
    input  logic [SLOT_BITS-1:0] fas_byte,
    input  logic [SLOT_BITS-1:0] nfas_byte,
    output logic                 nrz_out,
    output logic                 line_pos,
    output logic                 line_neg,
    output logic                 cfg_err
);
    localparam int SB_W = $clog2(SLOT_BITS);

    logic            ts0, odd_frame, fmt_bit;
    logic [SB_W-1:0] ts0_bit;

    e1_frame_pos #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_pos (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .ts0(ts0), .ts0_bit(ts0_bit), .odd_frame(odd_frame)
    );

    e1_ts0_insert #(.SLOT_BITS(SLOT_BITS)) u_ins (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ser_in(ser_in),
        .ts0(ts0), .ts0_bit(ts0_bit), .odd_frame(odd_frame),
        .pass_thru(ctrl[CTL_PASS]), .si_from_reg(ctrl[CTL_SIREG]),
        .fas_byte(fas_byte), .nfas_byte(nfas_byte),
        .fmt_bit(fmt_bit), .nrz_out(nrz_out)
    );

    e1_line_coder u_coder (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .hdb3_en(ctrl[CTL_HDB3]),
        .din(fmt_bit), .line_pos(line_pos), .line_neg(line_neg)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_err <= 1'b0;
        else        cfg_err <= (ctrl[CTL_PASS] && ctrl[CTL_SIREG])
                               || ((ctrl & CTL_RSVD_MASK) != '0);
    end

    p_cfg_combo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[CTL_PASS] && ctrl[CTL_SIREG]) |=> cfg_err);
    p_cfg_rsvd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl & CTL_RSVD_MASK) != '0) |=> cfg_err);
    p_cfg_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ctrl[CTL_PASS] && ctrl[CTL_SIREG]) && ((ctrl & CTL_RSVD_MASK) == '0))
        |=> !cfg_err);
endmodule

// File: tb/e1_ts0_formatter_bench.sv
module e1_ts0_formatter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       ser_in = 1'b0;
    logic [7:0] ctrl = 8'h00;
    logic [7:0] fas_byte = 8'h00;
    logic [7:0] nfas_byte = 8'h00;
    logic       nrz_out, line_pos, line_neg, cfg_err;

    always #4 clk = ~clk;

    e1_ts0_formatter u_e1_ts0_formatter (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ser_in(ser_in),
        .ctrl(ctrl), .fas_byte(fas_byte), .nfas_byte(nfas_byte),
        .nrz_out(nrz_out), .line_pos(line_pos), .line_neg(line_neg),
        .cfg_err(cfg_err)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit fbit [0:1023];
    bit dec  [0:1031];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit model(int n, bit d, logic [7:0] c, logic [7:0] fa, logic [7:0] nf);
        int p = n % 256;
        logic [7:0] r = ((n / 256) % 2 == 1) ? nf : fa;
        if (p == 0) return (c[4] && !c[7]) ? r[7] : d;
        if (p < 8)  return c[7] ? d : r[7 - p];
        return d;
    endfunction

    function automatic string tag_of(int n);
        int p = n % 256;
        if (p == 0) return "R2";
        if (p < 8)  return "R1";
        return "R5";
    endfunction

    task automatic do_reset(input logic [7:0] c);
        rst_n = 1'b0; ctrl = c; bit_en = 1'b0; ser_in = 1'b0;
        repeat (3) @(negedge clk);
        chk(!nrz_out && !line_pos && !line_neg && !cfg_err, "R11", "outputs in reset",
            {nrz_out, line_pos, line_neg, cfg_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // mode 0: random payload, mode 1: all zeros
    task automatic run_phase(input int nb, input int mode);
        bit hdb = ctrl[1];
        int last_pol = -1;
        bit have_v = 0;
        int pcount = 0;
        int zrun = 0;
        for (int n = 0; n < nb; n++) begin
            bit d;
            int m, idx, pol;
            d = (mode == 1) ? 1'b0 : (($urandom % 3) == 0);
            fbit[n] = model(n, d, ctrl, fas_byte, nfas_byte);
            bit_en = 1'b1; ser_in = d;
            @(negedge clk);
            bit_en = 1'b0;
            chk(nrz_out == fbit[n], tag_of(n), "nrz bit", nrz_out, fbit[n]);
            chk(!(line_pos && line_neg), "R7", "rail overlap", line_pos, 0);
            m = n - 4;
            idx = m + 8;
            if (line_pos || line_neg) begin
                pol = line_pos ? 1 : -1;
                if (pol == last_pol) begin
                    if (!hdb) chk(1'b0, "R10", "violation in AMI", 1, 0);
                    if (have_v) chk(pcount % 2 == 1, "R8", "pulses between violations", pcount, 1);
                    have_v = 1; pcount = 0;
                    dec[idx] = 1'b0;
                    for (int k = 1; k <= 3; k++) dec[idx - k] = 1'b0;
                end else begin
                    dec[idx] = 1'b1;
                    pcount++;
                end
                last_pol = pol;
                zrun = 0;
            end else begin
                dec[idx] = 1'b0;
                if (m >= 0) zrun++;
            end
            if (hdb && m >= 0) chk(zrun < 4, "R9", "zero run on line", zrun, 3);
            repeat ($urandom % 3) @(negedge clk);
        end
        for (int m = 0; m <= nb - 8; m++)
            chk(dec[m + 8] == fbit[m], hdb ? "R8" : "R10", "decoded rails", dec[m + 8], fbit[m]);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h0E1F_0A55);
        @(negedge clk);

        // R7 first pulse positive: a leading one after reset
        fas_byte = 8'hFF; nfas_byte = 8'h00;
        do_reset(8'h12);
        bit_en = 1'b1; ser_in = 1'b1;
        @(negedge clk); bit_en = 1'b0;
        repeat (4) begin
            bit_en = 1'b1; ser_in = 1'b1; @(negedge clk); bit_en = 1'b0; @(negedge clk);
        end
        chk(line_pos && !line_neg, "R7", "first pulse polarity", {line_pos, line_neg}, 2);

        // R1 R2 R6: register sourcing with international bit from register, HDB3
        fas_byte = 8'($urandom); nfas_byte = 8'($urandom);
        do_reset(8'h12);
        run_phase(600, 0);

        // R1 pass-through of the whole timeslot 0, HDB3
        fas_byte = 8'($urandom); nfas_byte = 8'($urandom);
        do_reset(8'h82);
        run_phase(600, 0);

        // R10 AMI, international bit from serial input
        fas_byte = 8'($urandom); nfas_byte = 8'($urandom);
        do_reset(8'h00);
        run_phase(600, 0);

        // R8 R9 all-zero line under HDB3
        fas_byte = 8'h00; nfas_byte = 8'h00;
        do_reset(8'h02);
        run_phase(300, 1);

        // R3 illegal combination: flag and serial international bit
        fas_byte = 8'hA5; nfas_byte = 8'h5A;
        do_reset(8'h92);
        chk(cfg_err == 1'b1, "R3", "cfg_err on combo", cfg_err, 1);
        run_phase(300, 0);

        // R4 reserved bits and clean words
        ctrl = 8'h04; @(negedge clk);
        chk(cfg_err == 1'b1, "R4", "reserved bit 2", cfg_err, 1);
        ctrl = 8'h12; @(negedge clk);
        chk(cfg_err == 1'b0, "R4", "legal word", cfg_err, 0);
        ctrl = 8'h40; @(negedge clk);
        chk(cfg_err == 1'b1, "R4", "reserved bit 6", cfg_err, 1);
        ctrl = 8'h80; @(negedge clk);
        chk(cfg_err == 1'b0, "R3", "pass-through alone", cfg_err, 0);
        ctrl = 8'h01; @(negedge clk);
        chk(cfg_err == 1'b1, "R4", "reserved bit 0", cfg_err, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule